// File: doc/BRIEF.md
# Integer ALU with Merged Branch Comparator

This block is the combinational integer datapath of a small 32-bit RISC-style core. It carries out the register-register and register-immediate arithmetic, logic, shift and set-less-than operations. The operand multiplexing in front of it has already chosen the second operand, which may be a register value or an immediate. A single mode input turns the same unit into the conditional-branch evaluator. The 3-bit operation code is then read as a branch condition, and the output reports taken (1) or not taken (0).

The operation code is the instruction's 3-bit function field. The 7-bit variant code is the instruction's upper function field; only its bit 5 carries meaning. One equality and less-than comparator is shared between the set-less-than operations and the branch conditions. The unit holds no state and has no clock. All inputs and outputs are plain combinational data pins, so no valid/ready handshake or back-pressure applies. The surrounding pipeline stage owns the timing.

Top module: `alu_brcmp_unit`

## Requirements
- R1: With `br_mode`=0 and `op_sel`=000, `result` is `opnd_a + opnd_b` when `op_var[5]`=0 and `opnd_a - opnd_b` when `op_var[5]`=1, both modulo 2^32.
- R2: With `br_mode`=0, `op_sel`=001 gives a logical left shift of `opnd_a`. `op_sel`=101 gives a right shift of `opnd_a`: logical when `op_var[5]`=0, arithmetic (sign-filling) when `op_var[5]`=1. The shift distance is `opnd_b[4:0]` only.
- R3: With `br_mode`=0, `op_sel`=010 gives 1 if `opnd_a` < `opnd_b` as signed values, else 0. `op_sel`=011 does the same comparison as unsigned values. Bits 31:1 of `result` are 0 for both.
- R4: With `br_mode`=0, `op_sel`=100, 110 and 111 give bitwise XOR, OR and AND of the operands.
- R5: `op_var[5]` has no effect for `op_sel` values other than 000 and 101 in arithmetic mode, and it has no effect in branch mode. All other `op_var` bits never affect `result`.
- R6: With `br_mode`=1, code 000 gives 1 when the operands are equal, and code 001 gives 1 when they differ.
- R7: With `br_mode`=1, code 100 gives 1 when `opnd_a` < `opnd_b` signed, and code 101 gives 1 when `opnd_a` >= `opnd_b` signed.
- R8: With `br_mode`=1, code 110 gives 1 when `opnd_a` < `opnd_b` unsigned, and code 111 gives 1 when `opnd_a` >= `opnd_b` unsigned.
- R9: With `br_mode`=1, codes 010 and 011 always give 0.
- R10: With `br_mode`=1, bits 31:1 of `result` are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| br_mode | input | 1 | 1 selects branch-condition evaluation, 0 selects arithmetic/logic |
| op_sel | input | 3 | Operation code, or branch condition code in branch mode |
| op_var | input | 7 | Variant code; bit 5 picks subtract or arithmetic right shift |
| opnd_a | input | 32 | First operand, signed |
| opnd_b | input | 32 | Second operand, signed, possibly an immediate |
| result | output | 32 | Operation result, or 0/1 taken flag in branch mode |

## Verification
The embedded assertions check, on every input change, that branch mode yields only 0 or 1 and that the two reserved branch codes never report taken. They also check that the set-less-than outputs are single-bit. On the shared comparator, they check that equality excludes less-than and that operands of opposite sign give opposite signed and unsigned orderings. The numerical correctness of every operation needs the bench's sweeps over corner operands against arithmetic expectations. So does the insensitivity to the variant bits and the five-bit truncation of the shift distance.

// File: rtl/alu_brcmp_pkg.sv
package alu_brcmp_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'b000,
    OP_SLL  = 3'b001,
    OP_SLT  = 3'b010,
    OP_SLTU = 3'b011,
    OP_XOR  = 3'b100,
    OP_SR   = 3'b101,
    OP_OR   = 3'b110,
    OP_AND  = 3'b111
  } arith_op_e;

  typedef enum logic [2:0] {
    BR_EQ   = 3'b000,
    BR_NE   = 3'b001,
    BR_RSV0 = 3'b010,
    BR_RSV1 = 3'b011,
    BR_LT   = 3'b100,
    BR_GE   = 3'b101,
    BR_LTU  = 3'b110,
    BR_GEU  = 3'b111
  } br_cond_e;

  localparam int VAR_ALT_BIT = 5;

  typedef struct packed {
    logic eq;
    logic lt_s;
    logic lt_u;
  } cmp_flags_t;
endpackage

// File: rtl/alu_cmp.sv
module alu_cmp
  import alu_brcmp_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic signed [WIDTH-1:0] a_i,
  input  logic signed [WIDTH-1:0] b_i,
  output cmp_flags_t              flags_o
);
  logic [WIDTH:0] diff_u;

  always_comb begin
    diff_u       = {1'b0, a_i} - {1'b0, b_i};
    flags_o.eq   = (a_i == b_i);
    flags_o.lt_u = diff_u[WIDTH];
    flags_o.lt_s = (a_i[WIDTH-1] != b_i[WIDTH-1]) ? a_i[WIDTH-1] : diff_u[WIDTH];
  end

  always_comb begin
    AST_EQ_EXCLUDES_LT: assert (!flags_o.eq || (!flags_o.lt_s && !flags_o.lt_u)); // R7
    AST_SIGN_SPLIT_ORDER: assert ((a_i[WIDTH-1] == b_i[WIDTH-1]) || (flags_o.lt_s != flags_o.lt_u)); // R8
  end
endmodule

// File: rtl/alu_arith.sv
module alu_arith
  import alu_brcmp_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [2:0]              op_i,
  input  logic                    alt_i,
  input  logic signed [WIDTH-1:0] a_i,
  input  logic signed [WIDTH-1:0] b_i,
  input  cmp_flags_t              flags_i,
  output logic [WIDTH-1:0]        res_o
);
  localparam int SHW = $clog2(WIDTH);

  logic [SHW-1:0]   shamt;
  logic [WIDTH-1:0] addsub, shl, shr;

  always_comb begin
    shamt  = b_i[SHW-1:0];
    addsub = alt_i ? (a_i - b_i) : (a_i + b_i);
    shl    = $unsigned(a_i) << shamt;
    shr    = alt_i ? $unsigned(a_i >>> shamt) : ($unsigned(a_i) >> shamt);
    unique case (arith_op_e'(op_i))
      OP_ADD:  res_o = addsub;
      OP_SLL:  res_o = shl;
      OP_SLT:  res_o = {{(WIDTH-1){1'b0}}, flags_i.lt_s};
      OP_SLTU: res_o = {{(WIDTH-1){1'b0}}, flags_i.lt_u};
      OP_XOR:  res_o = a_i ^ b_i;
      OP_SR:   res_o = shr;
      OP_OR:   res_o = a_i | b_i;
      OP_AND:  res_o = a_i & b_i;
      default: res_o = '0;
    endcase
  end

  always_comb begin
    AST_SLT_ONE_BIT: assert (!(op_i == OP_SLT || op_i == OP_SLTU) || (res_o[WIDTH-1:1] == '0)); // R3
  end
endmodule

// File: rtl/alu_branch.sv
module alu_branch
  import alu_brcmp_pkg::*;
(
  input  logic [2:0] cond_i,
  input  cmp_flags_t flags_i,
  output logic       taken_o
);
  always_comb begin
    unique case (br_cond_e'(cond_i))
      BR_EQ:   taken_o = flags_i.eq;
      BR_NE:   taken_o = !flags_i.eq;
      BR_LT:   taken_o = flags_i.lt_s;
      BR_GE:   taken_o = !flags_i.lt_s;
      BR_LTU:  taken_o = flags_i.lt_u;
      BR_GEU:  taken_o = !flags_i.lt_u;
      default: taken_o = 1'b0;
    endcase
  end

  always_comb begin
    AST_RSV_NEVER_TAKEN: assert (!(cond_i == BR_RSV0 || cond_i == BR_RSV1) || !taken_o); // R9
  end
endmodule

// File: rtl/alu_brcmp_unit.sv
module alu_brcmp_unit
  import alu_brcmp_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic                    br_mode,
  input  logic [2:0]              op_sel,
  input  logic [6:0]              op_var,
  input  logic signed [WIDTH-1:0] opnd_a,
  input  logic signed [WIDTH-1:0] opnd_b,
  output logic [WIDTH-1:0]        result
);
  cmp_flags_t       flags;
  logic [WIDTH-1:0] arith_res;
  logic             taken;
  logic             alt;

  assign alt = op_var[VAR_ALT_BIT];

  alu_cmp #(.WIDTH(WIDTH)) cmp_i (
    .a_i     (opnd_a),
    .b_i     (opnd_b),
    .flags_o (flags)
  );

  alu_arith #(.WIDTH(WIDTH)) arith_i (
    .op_i    (op_sel),
    .alt_i   (alt),
    .a_i     (opnd_a),
    .b_i     (opnd_b),
    .flags_i (flags),
    .res_o   (arith_res)
  );

  alu_branch branch_i (
    .cond_i  (op_sel),
    .flags_i (flags),
    .taken_o (taken)
  );

  assign result = br_mode ? {{(WIDTH-1){1'b0}}, taken} : arith_res;

  always_comb begin
    AST_BRANCH_FLAG_ONLY: assert (!br_mode || (result[WIDTH-1:1] == '0)); // R10
  end
endmodule

// File: tb/alu_brcmp_unit_tb_top.sv
module alu_brcmp_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        br_mode;
  logic [2:0]  op_sel;
  logic [6:0]  op_var;
  logic [31:0] opnd_a, opnd_b;
  logic [31:0] result;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  alu_brcmp_unit dut_i (
    .br_mode (br_mode),
    .op_sel  (op_sel),
    .op_var  (op_var),
    .opnd_a  (opnd_a),
    .opnd_b  (opnd_b),
    .result  (result)
  );

  function automatic logic [31:0] expect_val(bit bm, logic [2:0] f, logic [6:0] v,
                                             logic [31:0] a, logic [31:0] b);
    logic [4:0] s;
    s = b[4:0];
    if (bm) begin
      case (f)
        3'b000: return {31'd0, a == b};
        3'b001: return {31'd0, a != b};
        3'b100: return {31'd0, $signed(a) < $signed(b)};
        3'b101: return {31'd0, $signed(a) >= $signed(b)};
        3'b110: return {31'd0, a < b};
        3'b111: return {31'd0, a >= b};
        default: return 32'd0;
      endcase
    end
    case (f)
      3'b000: return v[5] ? a - b : a + b;
      3'b001: return a << s;
      3'b010: return {31'd0, $signed(a) < $signed(b)};
      3'b011: return {31'd0, a < b};
      3'b100: return a ^ b;
      3'b101: return v[5] ? 32'($signed(a) >>> s) : a >> s;
      3'b110: return a | b;
      default: return a & b;
    endcase
  endfunction

  function automatic string req_tag(bit bm, logic [2:0] f);
    if (bm) begin
      case (f)
        3'b000, 3'b001: return "R6";
        3'b100, 3'b101: return "R7";
        3'b110, 3'b111: return "R8";
        default:        return "R9";
      endcase
    end
    case (f)
      3'b000:         return "R1";
      3'b001, 3'b101: return "R2";
      3'b010, 3'b011: return "R3";
      default:        return "R4";
    endcase
  endfunction

  task automatic apply_check(bit bm, logic [2:0] f, logic [6:0] v,
                             logic [31:0] a, logic [31:0] b, string tag);
    logic [31:0] exp;
    @(posedge clk);
    br_mode = bm; op_sel = f; op_var = v; opnd_a = a; opnd_b = b;
    exp = expect_val(bm, f, v, a, b);
    @(negedge clk);
    n_checks++;
    if (result !== exp) begin
      n_fail++;
      $display("FAIL %s mode=%0b op=%03b var=%07b a=%08h b=%08h actual=%08h expected=%08h",
               tag, bm, f, v, a, b, result, exp);
    end
    if (bm && result[31:1] != 31'd0) begin
      n_checks++;
      n_fail++;
      $display("FAIL R10 actual=%08h expected=0 or 1", result);
    end
  endtask

  logic [31:0] corners [10];
  logic [6:0]  vars    [4];

  initial begin
    corners[0] = 32'h0000_0000; corners[1] = 32'h0000_0001;
    corners[2] = 32'hFFFF_FFFF; corners[3] = 32'h8000_0000;
    corners[4] = 32'h7FFF_FFFF; corners[5] = 32'h0000_001F;
    corners[6] = 32'h0000_0020; corners[7] = 32'h1234_5678;
    corners[8] = 32'hFEDC_BA98; corners[9] = 32'hFFFF_FFE4;
    vars[0] = 7'h00; vars[1] = 7'h20; vars[2] = 7'h5F; vars[3] = 7'h7F;
    br_mode = 1'b0; op_sel = 3'b000; op_var = 7'h00; opnd_a = '0; opnd_b = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_checks++;
    if (result !== 32'd0) begin
      n_fail++;
      $display("FAIL R1 idle zero inputs actual=%08h expected=00000000", result);
    end
    // R5: every variant code, including bit 5 on unrelated ops and in branch mode
    for (int m = 0; m < 2; m++)
      for (int f = 0; f < 8; f++)
        for (int v = 0; v < 4; v++)
          for (int i = 0; i < 10; i++)
            for (int j = 0; j < 10; j++)
              apply_check(m[0], f[2:0], vars[v], corners[i], corners[j],
                          (v >= 2) ? "R5" : req_tag(m[0], f[2:0]));
    // R2: shift distance uses only the low five bits
    for (int k = 0; k < 64; k++) begin
      apply_check(1'b0, 3'b001, 7'h00, 32'h8000_0F01, 32'(k) | 32'hABCD_0000, "R2");
      apply_check(1'b0, 3'b101, 7'h00, 32'h8000_0F01, 32'(k), "R2");
      apply_check(1'b0, 3'b101, 7'h20, 32'h8000_0F01, 32'(k), "R2");
    end
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule